// File: doc/BRIEF.md
# Saturating Vector Extract-Narrow Unit

This block takes a 128-bit source vector of double-width elements and turns each element into one half its width. A value that cannot fit in the narrower type is clamped to the nearest bound of that type. A 2-bit width code sets the narrow element width to 8, 16 or 32 bits. A 2-bit mode code sets how the wide element is read and what range the narrow result has:

- signed in, signed out
- signed in, unsigned out
- unsigned in, unsigned out

In vector form the unit fills a whole 64-bit result half, one lane per element. In scalar form it narrows only the lowest element.

The result is merged into the previous destination value and captured in a register one cycle after a start strobe. It can go to the lower half, which clears the upper half. It can go to the upper half, which keeps the lower 64 bits of the old destination. A sticky saturation flag collects clamping events across operations until a dedicated clear input resets it. A reserved width or mode code causes no write. Instead it raises a one-cycle illegal indication.

Top module: `sat_narrow_unit`

## Requirements
- R1: In vector form, with esize = 8 << size_i, source element e occupies src_i bits [e*2*esize +: 2*esize] and its narrowed value lands in result bits [e*esize +: esize], for e = 0 .. 64/esize-1 (size_i 0, 1, 2 give 8, 4, 2 lanes).
- R2: With mode_i = 0 (signed to signed), each element is read as two's complement and clamped to [-2^(esize-1), 2^(esize-1)-1]; an in-range element keeps its low esize bits.
- R3: With mode_i = 1 (signed to unsigned), each element is read as two's complement; negative values give 0 and values above 2^esize-1 give 2^esize-1.
- R4: With mode_i = 2 (unsigned to unsigned), each element is read as unsigned and values above 2^esize-1 give 2^esize-1.
- R5: With scalar_i = 1, only the element in src_i bits [2*esize-1:0] is narrowed and written to dst_o bits [esize-1:0]; every other dst_o bit becomes 0 whatever upper_i is.
- R6: In vector form with upper_i = 0, the 64-bit result goes to dst_o[63:0] and dst_o[127:64] becomes 0.
- R7: In vector form with upper_i = 1, the result goes to dst_o[127:64] and dst_o[63:0] takes dst_old_i[63:0].
- R8: qc_o rises after a legal operation in which any element that is written saturates. Lanes ignored in scalar form never set it.
- R9: qc_o stays set until qc_clr_i is asserted. A clear in the same cycle as a saturating operation leaves qc_o set.
- R10: A start with mode_i = 3 or size_i = 3 pulses illegal_o one cycle later and leaves dst_o and qc_o unchanged.
- R11: done_o pulses for exactly one cycle, one cycle after each start_i, and the matching dst_o is valid in that same cycle.
- R12: After synchronous reset, dst_o is 0 and qc_o, done_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts one operation |
| src_i | input | 128 | Source vector of wide elements |
| dst_old_i | input | 128 | Previous destination value |
| size_i | input | 2 | Narrow width code, esize = 8 << size_i, 3 reserved |
| mode_i | input | 2 | 0 signed/signed, 1 signed/unsigned, 2 unsigned/unsigned, 3 reserved |
| scalar_i | input | 1 | 1 = single element, 0 = full vector |
| upper_i | input | 1 | Vector form: 1 = write upper half, keep lower half |
| qc_clr_i | input | 1 | Clears the sticky saturation flag |
| dst_o | output | 128 | Registered new destination |
| done_o | output | 1 | One-cycle pulse marking a completed operation |
| illegal_o | output | 1 | One-cycle pulse for a reserved code |
| qc_o | output | 1 | Sticky saturation flag |

## Verification
A fault in the mode decode or a lane's bound selection shows up on dst_o in the cycle after start. It appears as a clamped lane where the raw bits were expected, or as the opposite bound, so boundary values on both sides of each range are fed through every width. Errors in the half-merge show up in the same cycle as stray bits in the half that should be zero or kept. A corrupted sticky flag shows up on qc_o only at the next operation or clear, so the bench checks it after non-saturating operations, illegal operations and clears as well as after saturating ones.

// File: rtl/sn_pkg.sv
package sn_pkg;
  typedef enum logic [1:0] {
    MODE_SS  = 2'd0,
    MODE_SU  = 2'd1,
    MODE_UU  = 2'd2,
    MODE_RSV = 2'd3
  } nar_mode_e;

  localparam logic [1:0] SIZE_RSV = 2'd3;
  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/sn_mode_dec.sv
module sn_mode_dec
  import sn_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] size_i,
  output logic       src_signed_o,
  output logic       dst_signed_o,
  output logic       legal_o
);
  always_comb begin
    src_signed_o = 1'b0;
    dst_signed_o = 1'b0;
    case (nar_mode_e'(mode_i))
      MODE_SS: begin src_signed_o = 1'b1; dst_signed_o = 1'b1; end
      MODE_SU: begin src_signed_o = 1'b1; dst_signed_o = 1'b0; end
      MODE_UU: begin src_signed_o = 1'b0; dst_signed_o = 1'b0; end
      default: begin src_signed_o = 1'b0; dst_signed_o = 1'b0; end
    endcase
    legal_o = (nar_mode_e'(mode_i) != MODE_RSV) && (size_i != SIZE_RSV);
  end
endmodule

// File: rtl/sn_lane.sv
module sn_lane #(
  parameter int OUT_W = 8
) (
  input  logic [2*OUT_W-1:0] wide_i,
  input  logic               src_signed_i,
  input  logic               dst_signed_i,
  output logic [OUT_W-1:0]   nar_o,
  output logic               sat_o
);
  localparam int IW = 2 * OUT_W;
  localparam int XW = IW + 1;

  logic signed [XW-1:0] val;
  logic signed [XW-1:0] hi;
  logic signed [XW-1:0] lo;

  // One extended signed domain covers both source interpretations.
  always_comb begin
    val = $signed({src_signed_i & wide_i[IW-1], wide_i});
    if (dst_signed_i) begin
      hi = $signed((XW'(1) << (OUT_W - 1)) - XW'(1));
      lo = -$signed(XW'(1) << (OUT_W - 1));
    end else begin
      hi = $signed((XW'(1) << OUT_W) - XW'(1));
      lo = '0;
    end
    if (val > hi) begin
      nar_o = hi[OUT_W-1:0];
      sat_o = 1'b1;
    end else if (val < lo) begin
      nar_o = lo[OUT_W-1:0];
      sat_o = 1'b1;
    end else begin
      nar_o = wide_i[OUT_W-1:0];
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/sn_narrow_core.sv
module sn_narrow_core
  import sn_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic [2*HALF_W-1:0] src_i,
  input  logic [1:0]          size_i,
  input  logic                src_signed_i,
  input  logic                dst_signed_i,
  input  logic                scalar_i,
  output logic [HALF_W-1:0]   res_o,
  output logic                sat_o
);
  logic [HALF_W-1:0] res_by_size [NUM_SIZES];
  logic              sat_by_size [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int OW = 8 << k;
    localparam int NL = HALF_W / OW;
    logic [HALF_W-1:0] lane_res;
    logic [NL-1:0]     lane_sat;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      sn_lane #(.OUT_W(OW)) u_lane (
        .wide_i       (src_i[l*2*OW +: 2*OW]),
        .src_signed_i (src_signed_i),
        .dst_signed_i (dst_signed_i),
        .nar_o        (lane_res[l*OW +: OW]),
        .sat_o        (lane_sat[l])
      );
    end

    assign res_by_size[k] = scalar_i ? {{(HALF_W-OW){1'b0}}, lane_res[OW-1:0]} : lane_res;
    assign sat_by_size[k] = scalar_i ? lane_sat[0] : |lane_sat;
  end

  always_comb begin
    res_o = '0;
    sat_o = 1'b0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (size_i == 2'(k)) begin
        res_o = res_by_size[k];
        sat_o = sat_by_size[k];
      end
    end
  end
endmodule

// File: rtl/sat_narrow_unit.sv
module sat_narrow_unit #(
  parameter int HALF_W = 64,
  localparam int VEC_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_old_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       mode_i,
  input  logic             scalar_i,
  input  logic             upper_i,
  input  logic             qc_clr_i,
  output logic [VEC_W-1:0] dst_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic             qc_o
);
  logic              src_signed;
  logic              dst_signed;
  logic              legal;
  logic [HALF_W-1:0] res;
  logic              any_sat;
  logic [VEC_W-1:0]  merged;
  logic              go;

  sn_mode_dec u_dec (
    .mode_i       (mode_i),
    .size_i       (size_i),
    .src_signed_o (src_signed),
    .dst_signed_o (dst_signed),
    .legal_o      (legal)
  );

  sn_narrow_core #(.HALF_W(HALF_W)) u_core (
    .src_i        (src_i),
    .size_i       (size_i),
    .src_signed_i (src_signed),
    .dst_signed_i (dst_signed),
    .scalar_i     (scalar_i),
    .res_o        (res),
    .sat_o        (any_sat)
  );

  assign go = start_i & legal;

  always_comb begin
    if (!scalar_i && upper_i) merged = {res, dst_old_i[HALF_W-1:0]};
    else                      merged = {{HALF_W{1'b0}}, res};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_o     <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      qc_o      <= 1'b0;
    end else begin
      done_o    <= start_i;
      illegal_o <= start_i & ~legal;
      if (go) dst_o <= merged;
      qc_o <= (qc_o & ~qc_clr_i) | (go & any_sat);
    end
  end
endmodule

// File: rtl/sn_checker.sv
module sn_checker #(
  parameter int HALF_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [2*HALF_W-1:0] dst_old_i,
  input logic [1:0]        size_i,
  input logic [1:0]        mode_i,
  input logic              scalar_i,
  input logic              upper_i,
  input logic              qc_clr_i,
  input logic [2*HALF_W-1:0] dst_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic              qc_o
);
  logic bad;
  assign bad = (mode_i == 2'd3) || (size_i == 2'd3);

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o); // R11
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !done_o); // R11
  AST_QC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (qc_o && !qc_clr_i) |=> qc_o); // R9
  AST_ILLEGAL_KEEPS_DST: assert property (@(posedge clk) disable iff (rst)
    (start_i && bad) |=> ($stable(dst_o) && illegal_o)); // R10
  AST_ILLEGAL_KEEPS_QC: assert property (@(posedge clk) disable iff (rst)
    (start_i && bad && !qc_clr_i) |=> $stable(qc_o)); // R10
  AST_UPPER_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (start_i && !bad && !scalar_i && upper_i) |=>
      (dst_o[HALF_W-1:0] == $past(dst_old_i[HALF_W-1:0]))); // R7
  AST_LOW_CLEARS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (start_i && !bad && (scalar_i || !upper_i)) |=>
      (dst_o[2*HALF_W-1:HALF_W] == '0)); // R6
endmodule

bind sat_narrow_unit sn_checker #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .dst_old_i (dst_old_i),
  .size_i    (size_i),
  .mode_i    (mode_i),
  .scalar_i  (scalar_i),
  .upper_i   (upper_i),
  .qc_clr_i  (qc_clr_i),
  .dst_o     (dst_o),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .qc_o      (qc_o)
);

// File: tb/sat_narrow_unit_tb.sv
`timescale 1ns/1ps
module sat_narrow_unit_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         start_i = 1'b0;
  logic [127:0] src_i = '0;
  logic [127:0] dst_old_i = '0;
  logic [1:0]   size_i = '0;
  logic [1:0]   mode_i = '0;
  logic         scalar_i = 1'b0;
  logic         upper_i = 1'b0;
  logic         qc_clr_i = 1'b0;
  logic [127:0] dst_o;
  logic         done_o;
  logic         illegal_o;
  logic         qc_o;

  int n_chk = 0;
  int n_fail = 0;
  logic         exp_qc = 1'b0;
  logic [127:0] exp_dst = '0;

  always #2.5 clk = ~clk;

  sat_narrow_unit u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i), .dst_old_i(dst_old_i),
    .size_i(size_i), .mode_i(mode_i), .scalar_i(scalar_i), .upper_i(upper_i),
    .qc_clr_i(qc_clr_i), .dst_o(dst_o), .done_o(done_o), .illegal_o(illegal_o), .qc_o(qc_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference narrowing from the requirements.
  function automatic logic [127:0] ref_op(input logic [127:0] src, input logic [127:0] old,
      input int sz, input int md, input logic sc, input logic up, output logic sat);
    int ow = 8 << sz;
    int iw = 2 * ow;
    int nl = sc ? 1 : 64 / ow;
    logic s_in = (md != 2);
    logic s_out = (md == 0);
    logic [63:0] res = '0;
    logic [63:0] imask = (iw >= 64) ? '1 : ((64'd1 << iw) - 64'd1);
    logic [63:0] omask = (64'd1 << ow) - 64'd1;
    sat = 1'b0;
    for (int e = 0; e < nl; e++) begin
      logic [63:0] w = 64'(src >> (e * iw)) & imask;
      logic signed [66:0] v = $signed({3'b0, w});
      logic signed [66:0] hi;
      logic signed [66:0] lo;
      logic [63:0] r;
      if (s_in && w[iw-1]) v = v - (67'sd1 <<< iw);
      hi = s_out ? (67'sd1 <<< (ow - 1)) - 1 : (67'sd1 <<< ow) - 1;
      lo = s_out ? -(67'sd1 <<< (ow - 1)) : 67'sd0;
      if (v > hi) begin r = hi[63:0]; sat = 1'b1; end
      else if (v < lo) begin r = lo[63:0]; sat = 1'b1; end
      else r = w;
      res = res | ((r & omask) << (e * ow));
    end
    if (!sc && up) return {res, old[63:0]};
    return {64'b0, res};
  endfunction

  task automatic run_op(input string req, input logic [127:0] src, input logic [127:0] old,
      input int sz, input int md, input logic sc, input logic up);
    logic s;
    logic [127:0] e;
    logic bad = (sz == 3) || (md == 3);
    @(negedge clk);
    src_i = src; dst_old_i = old; size_i = 2'(sz); mode_i = 2'(md);
    scalar_i = sc; upper_i = up; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!bad) begin
      e = ref_op(src, old, sz, md, sc, up, s);
      exp_dst = e;
      exp_qc = exp_qc | s;
    end
    chk({req, " dst"}, dst_o, exp_dst);
    chk({req, " done"}, 128'(done_o), 128'(1));
    chk({req, " illegal"}, 128'(illegal_o), 128'(bad));
    chk({req, " qc"}, 128'(qc_o), 128'(exp_qc));
  endtask

  task automatic t_reset;
    chk("R12 dst", dst_o, '0);
    chk("R12 qc", 128'(qc_o), 128'(0));
    chk("R12 done", 128'(done_o), 128'(0));
    chk("R12 illegal", 128'(illegal_o), 128'(0));
  endtask

  localparam logic [127:0] PAT_A = 128'h7FFF_8000_0080_FF7F_007F_FF80_0001_FFFF;
  localparam logic [127:0] PAT_B = 128'h0000_7FFF_FFFF_8000_0000_8000_FFFF_7FFF;
  localparam logic [127:0] PAT_C = 128'h0000_0000_FFFF_FFFF_8000_0000_7FFF_FFFF;
  localparam logic [127:0] PAT_D = 128'h0000_0010_0000_0020_0030_0040_0050_0060;
  localparam logic [127:0] OLD   = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA;

  task automatic t_signed;
    for (int sz = 0; sz < 3; sz++) begin
      run_op("R2 R1 signed", PAT_A, OLD, sz, 0, 1'b0, 1'b0);
      run_op("R2 R1 signed", PAT_B, OLD, sz, 0, 1'b0, 1'b0);
    end
    // Exact bounds: 0x007F -> 7F, 0xFF80 -> 80 unsaturated
    run_op("R2 bounds", 128'h007F_FF80_007F_FF80_007F_FF80_007F_FF80, OLD, 0, 0, 1'b0, 1'b0);
    chk("R2 exact bounds", dst_o, 128'h0000_0000_0000_0000_7F80_7F80_7F80_7F80);
  endtask

  task automatic t_uns_from_signed;
    for (int sz = 0; sz < 3; sz++) begin
      run_op("R3 signed-to-unsigned", PAT_A, OLD, sz, 1, 1'b0, 1'b0);
      run_op("R3 signed-to-unsigned", PAT_C, OLD, sz, 1, 1'b0, 1'b0);
    end
    // 0x8000 -> 00, 0x7FFF -> FF, 0x00FF -> FF, 0x0100 -> FF
    run_op("R3 fixed", 128'h0000_0000_0000_0000_8000_7FFF_00FF_0100, OLD, 0, 1, 1'b0, 1'b0);
    chk("R3 fixed value", dst_o, 128'h0000_0000_0000_0000_0000_0000_00FF_FFFF);
  endtask

  task automatic t_unsigned;
    for (int sz = 0; sz < 3; sz++) begin
      run_op("R4 unsigned", PAT_B, OLD, sz, 2, 1'b0, 1'b0);
      run_op("R4 unsigned", PAT_C, OLD, sz, 2, 1'b0, 1'b0);
    end
    run_op("R4 fixed", 128'h0000_0000_0000_0000_8000_00FF_0100_0012, OLD, 0, 2, 1'b0, 1'b0);
    chk("R4 fixed value", dst_o, 128'h0000_0000_0000_0000_0000_0000_FFFF_FF12);
  endtask

  task automatic t_scalar;
    // Upper lanes would saturate but are outside scalar scope.
    do_clear();
    run_op("R5 scalar", 128'hFFFF_FFFF_7FFF_7FFF_7FFF_7FFF_7FFF_0012, OLD, 0, 0, 1'b1, 1'b1);
    chk("R5 scalar value", dst_o, 128'h12);
    chk("R8 scalar lanes ignored", 128'(qc_o), 128'(0));
    for (int sz = 0; sz < 3; sz++)
      run_op("R5 scalar sizes", PAT_A, OLD, sz, 1, 1'b1, 1'b0);
  endtask

  task automatic t_halves;
    run_op("R6 lower", PAT_D, OLD, 0, 0, 1'b0, 1'b0);
    chk("R6 lower value", dst_o, 128'h0000_0000_0000_0000_0010_0020_3040_5060);
    run_op("R7 upper", PAT_D, OLD, 0, 0, 1'b0, 1'b1);
    chk("R7 upper value", dst_o, 128'h0010_0020_3040_5060_89AB_CDEF_5555_AAAA);
    for (int sz = 0; sz < 3; sz++)
      run_op("R7 upper sizes", PAT_A, OLD, sz, 2, 1'b0, 1'b1);
  endtask

  task automatic do_clear;
    @(negedge clk);
    qc_clr_i = 1'b1;
    @(negedge clk);
    qc_clr_i = 1'b0;
    exp_qc = 1'b0;
  endtask

  task automatic t_sticky;
    do_clear();
    chk("R9 cleared", 128'(qc_o), 128'(0));
    run_op("R8 no sat", PAT_D, OLD, 0, 0, 1'b0, 1'b0);
    chk("R8 stays low", 128'(qc_o), 128'(0));
    run_op("R8 sat sets", PAT_A, OLD, 0, 2, 1'b0, 1'b0);
    chk("R8 set", 128'(qc_o), 128'(1));
    run_op("R9 holds", PAT_D, OLD, 0, 0, 1'b0, 1'b0);
    chk("R9 held", 128'(qc_o), 128'(1));
    // Clear and saturating op in the same cycle: set wins.
    @(negedge clk);
    src_i = PAT_A; dst_old_i = OLD; size_i = 0; mode_i = 2; scalar_i = 0; upper_i = 0;
    start_i = 1'b1; qc_clr_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; qc_clr_i = 1'b0;
    chk("R9 set over clear", 128'(qc_o), 128'(1));
    do_clear();
    chk("R9 clear works", 128'(qc_o), 128'(0));
  endtask

  task automatic t_illegal;
    run_op("R8 prime", PAT_A, OLD, 1, 0, 1'b0, 1'b0);
    run_op("R10 mode3", PAT_A, 128'h1, 0, 3, 1'b0, 1'b0);
    run_op("R10 size3", PAT_A, 128'h1, 3, 0, 1'b0, 1'b1);
    do_clear();
    run_op("R10 mode3 qc clear", PAT_A, 128'h1, 0, 3, 1'b0, 1'b0);
    chk("R10 qc unchanged", 128'(qc_o), 128'(0));
    @(negedge clk);
    chk("R11 done single", 128'(done_o), 128'(0));
    chk("R10 illegal single", 128'(illegal_o), 128'(0));
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_signed();
    t_uns_from_signed();
    t_unsigned();
    t_scalar();
    t_halves();
    t_sticky();
    t_illegal();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule